// File: doc/BRIEF.md
# Chain Readout Token Controller

This block is the per-chip readout stage of a front-end chip that sits in a chain of chips on one shared open-collector data bus. It stays idle until a start token arrives. The first chip gets this token from the acquisition system, and every later chip gets it from the end pulse of the chip before it. When the token arrives, the block drives the transmit-enable line and sends its stored event records, one bit per clock. It reads the records word by word from local storage. When the last bit has gone out, it issues a one-clock end pulse that acts as the start token of the next chip.

A configuration input selects one of two start inputs and the matching end output. This lets the chain route around a dead neighbour. The data and transmit-enable outputs are driven as two identical copies. Each event record is a bunch-crossing word followed by one word per channel. A channel word carries a hit flag, a gain flag and a 12-bit time or charge value. The block sends these words unchanged and puts an 8-bit chip identifier in front of them.

Top module: `chain_readout_ctrl`

## Requirements
- R1: While rst_ni is low, all data, transmit-enable and end outputs are 0 (released).
- R2: With path_sel_i = 0, only start_a_i starts a readout and only end_a_o pulses. With path_sel_i = 1, only start_b_i starts a readout and only end_b_o pulses. A pulse on the unselected start input has no effect on any output. The selection is captured when the token is accepted.
- R3: The token is sampled on a rising clock edge while the block is idle. For a non-empty readout, transmit-enable goes high in the cycle after that edge, which is one clock before the first data bit. It goes low one clock after the last data bit.
- R4: The serial stream is the chip ID (ID_W bits) followed by ev_count_i × (N_CH+1) storage words of WORD_W bits each. Words are sent in ascending address order starting at address 0, and every field is sent MSB first. Within each record, word 0 is the bunch-crossing ID and each following word is one channel: bit 15 = hit, bit 14 = gain, bits 11:0 = value. These words are sent exactly as stored.
- R5: The data line is 0 in every cycle in which transmit-enable is 0, and also in the lead cycle and the tail cycle.
- R6: The end pulse on the selected end output lasts exactly one clock. For a non-empty readout, it falls in the same cycle in which transmit-enable falls.
- R7: If ev_count_i = 0 when the token is accepted, transmit-enable stays 0 and the end pulse appears in the cycle after the token edge.
- R8: A start pulse that arrives while a readout is in progress, including its end cycle, is ignored. Only one end pulse results.
- R9: dout_b_o always equals dout_a_o, and txon_b_o always equals txon_a_o.
- R10: Storage is read with rd_en_o / rd_addr_o, and the word appears on rd_data_i one clock later. The sequence is the same for the largest event count, EV_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| path_sel_i | input | 1 | Token path select (0 = path a, 1 = path b) |
| start_a_i | input | 1 | Start token, path a |
| start_b_i | input | 1 | Start token, path b |
| chip_id_i | input | ID_W | Identifier sent ahead of the records |
| ev_count_i | input | clog2(EV_MAX+1) | Number of stored events |
| rd_en_o | output | 1 | Storage read strobe |
| rd_addr_o | output | clog2(EV_MAX*(N_CH+1)+1) | Storage word address |
| rd_data_i | input | WORD_W | Storage word, valid one clock after the strobe |
| dout_a_o | output | 1 | Serial data, copy a |
| dout_b_o | output | 1 | Serial data, copy b |
| txon_a_o | output | 1 | Transmit enable, copy a |
| txon_b_o | output | 1 | Transmit enable, copy b |
| end_a_o | output | 1 | End token, path a |
| end_b_o | output | 1 | End token, path b |

## Verification
Let the token be sampled at edge k and let L be the stream length in bits. Then transmit-enable is due after edge k, data bit i is due after edge k+1+i, the tail cycle is due after edge k+L+1, and the end pulse is due after edge k+L+2. For an empty chip, the end pulse is due after edge k. The bench reference model turns each accepted token into a queue with one expected output triple per cycle, and it pops one entry at every falling edge, so every output is compared in the cycle it is due. The model accepts tokens only while it is idle and not in its end cycle, so the start pulses that the design should ignore are checked on the outputs in the same way.

// File: rtl/chain_ro_pkg.sv
package chain_ro_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_END
  } ro_state_e;
endpackage

// File: rtl/ro_token_sel.sv
module ro_token_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic path_sel_i,
  input  logic start_a_i,
  input  logic start_b_i,
  input  logic take_i,
  input  logic end_i,
  output logic start_o,
  output logic end_a_o,
  output logic end_b_o
);
  logic path_q;

  assign start_o = path_sel_i ? start_b_i : start_a_i;

  // hand-off path is frozen when the token is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     path_q <= 1'b0;
    else if (take_i) path_q <= path_sel_i;
  end

  assign end_a_o = end_i & ~path_q;
  assign end_b_o = end_i &  path_q;
endmodule

// File: rtl/ro_serializer.sv
module ro_serializer
  import chain_ro_pkg::*;
#(
  parameter int N_CH   = 64,
  parameter int EV_MAX = 15,
  parameter int WORD_W = 16,
  parameter int ID_W   = 8,
  localparam int EV_W    = $clog2(EV_MAX + 1),
  localparam int REC_W   = N_CH + 1,
  localparam int TOT_MAX = EV_MAX * REC_W,
  localparam int CNT_W   = $clog2(TOT_MAX + 1),
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   chip_id_i,
  input  logic [EV_W-1:0]   ev_count_i,
  output logic              rd_en_o,
  output logic [CNT_W-1:0]  rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              take_o,
  output logic              dout_o,
  output logic              txon_o,
  output logic              end_o
);
  ro_state_e         state_q;
  logic [WORD_W-1:0] sreg_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  ld_left_q;
  logic [CNT_W-1:0]  rd_ptr_q;
  logic [EV_W-1:0]   ev_eff;
  logic [CNT_W-1:0]  tot_words;
  logic              last_bit;
  logic              load_word;

  assign ev_eff    = (ev_count_i > EV_W'(EV_MAX)) ? EV_W'(EV_MAX) : ev_count_i;
  assign tot_words = CNT_W'(ev_eff) * CNT_W'(REC_W);

  assign take_o    = (state_q == ST_IDLE) && start_i;
  assign last_bit  = (bit_q == '0);
  assign load_word = (state_q == ST_SHIFT) && last_bit && (ld_left_q != '0);

  // single-word prefetch: next word is fetched as the current one is loaded
  assign rd_en_o   = (state_q == ST_LEAD) || (load_word && (ld_left_q > CNT_W'(1)));
  assign rd_addr_o = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sreg_q    <= '0;
      bit_q     <= '0;
      ld_left_q <= '0;
      rd_ptr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ld_left_q <= tot_words;
          rd_ptr_q  <= '0;
          state_q   <= (tot_words == '0) ? ST_END : ST_LEAD;
        end
        ST_LEAD: begin
          sreg_q   <= {chip_id_i, {(WORD_W-ID_W){1'b0}}};
          bit_q    <= BIT_W'(ID_W - 1);
          rd_ptr_q <= rd_ptr_q + CNT_W'(1);
          state_q  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!last_bit) begin
            sreg_q <= sreg_q << 1;
            bit_q  <= bit_q - BIT_W'(1);
          end else if (load_word) begin
            sreg_q    <= rd_data_i;
            bit_q     <= BIT_W'(WORD_W - 1);
            ld_left_q <= ld_left_q - CNT_W'(1);
            if (rd_en_o) rd_ptr_q <= rd_ptr_q + CNT_W'(1);
          end else begin
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: state_q <= ST_END;
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dout_o = (state_q == ST_SHIFT) & sreg_q[WORD_W-1];
  assign txon_o = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TAIL);
  assign end_o  = (state_q == ST_END);
endmodule

// File: rtl/ro_bus_dup.sv
module ro_bus_dup #(
  parameter int COPIES = 2
) (
  input  logic              dout_i,
  input  logic              txon_i,
  output logic [COPIES-1:0] dout_o,
  output logic [COPIES-1:0] txon_o
);
  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    assign dout_o[g] = dout_i & txon_i;
    assign txon_o[g] = txon_i;
  end
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl #(
  parameter int N_CH   = 64,
  parameter int EV_MAX = 15,
  parameter int WORD_W = 16,
  parameter int ID_W   = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   path_sel_i,
  input  logic                                   start_a_i,
  input  logic                                   start_b_i,
  input  logic [ID_W-1:0]                        chip_id_i,
  input  logic [$clog2(EV_MAX+1)-1:0]            ev_count_i,
  output logic                                   rd_en_o,
  output logic [$clog2(EV_MAX*(N_CH+1)+1)-1:0]   rd_addr_o,
  input  logic [WORD_W-1:0]                      rd_data_i,
  output logic                                   dout_a_o,
  output logic                                   dout_b_o,
  output logic                                   txon_a_o,
  output logic                                   txon_b_o,
  output logic                                   end_a_o,
  output logic                                   end_b_o
);
  logic       start_sel;
  logic       take;
  logic       ser_dout;
  logic       ser_txon;
  logic       ser_end;
  logic [1:0] dout_v;
  logic [1:0] txon_v;

  ro_token_sel u_tok (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .path_sel_i (path_sel_i),
    .start_a_i  (start_a_i),
    .start_b_i  (start_b_i),
    .take_i     (take),
    .end_i      (ser_end),
    .start_o    (start_sel),
    .end_a_o    (end_a_o),
    .end_b_o    (end_b_o)
  );

  ro_serializer #(
    .N_CH   (N_CH),
    .EV_MAX (EV_MAX),
    .WORD_W (WORD_W),
    .ID_W   (ID_W)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_sel),
    .chip_id_i  (chip_id_i),
    .ev_count_i (ev_count_i),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .take_o     (take),
    .dout_o     (ser_dout),
    .txon_o     (ser_txon),
    .end_o      (ser_end)
  );

  ro_bus_dup #(.COPIES(2)) u_dup (
    .dout_i (ser_dout),
    .txon_i (ser_txon),
    .dout_o (dout_v),
    .txon_o (txon_v)
  );

  assign dout_a_o = dout_v[0];
  assign dout_b_o = dout_v[1];
  assign txon_a_o = txon_v[0];
  assign txon_b_o = txon_v[1];
endmodule

// File: rtl/chain_readout_chk.sv
module chain_readout_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dout_a_o,
  input logic txon_a_o,
  input logic end_a_o,
  input logic end_b_o
);
  a_r5_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txon_a_o |-> !dout_a_o);

  a_r3_lead_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txon_a_o) |-> !dout_a_o);

  a_r6_end_on_tx_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txon_a_o) |-> (end_a_o || end_b_o));

  a_r6_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_a_o || end_b_o) |=> !(end_a_o || end_b_o));

  a_r2_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({end_a_o, end_b_o}));

  a_r6_no_tx_with_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_a_o || end_b_o) |-> !txon_a_o);
endmodule

bind chain_readout_ctrl chain_readout_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dout_a_o (dout_a_o),
  .txon_a_o (txon_a_o),
  .end_a_o  (end_a_o),
  .end_b_o  (end_b_o)
);

// File: tb/chain_readout_ctrl_tb.sv
module chain_readout_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 4;
  localparam int EV_MAX = 15;
  localparam int WORD_W = 16;
  localparam int ID_W   = 8;
  localparam int EV_W   = $clog2(EV_MAX + 1);
  localparam int CNT_W  = $clog2(EV_MAX * (N_CH + 1) + 1);

  typedef struct packed { logic tx; logic d; logic e; } slot_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              path_sel = 1'b0;
  logic              start_a = 1'b0;
  logic              start_b = 1'b0;
  logic [ID_W-1:0]   chip_id = '0;
  logic [EV_W-1:0]   ev_count = '0;
  logic              rd_en;
  logic [CNT_W-1:0]  rd_addr;
  logic [WORD_W-1:0] mem_q = '0;
  logic              dout_a, dout_b, txon_a, txon_b, end_a, end_b;

  int    checks = 0;
  int    errors = 0;
  int    seed   = 1;
  int    end_seen = 0;
  logic  model_busy = 1'b0;
  logic  sel_m = 1'b0;
  slot_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_readout_ctrl #(.N_CH(N_CH), .EV_MAX(EV_MAX), .WORD_W(WORD_W), .ID_W(ID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .path_sel_i(path_sel),
    .start_a_i(start_a), .start_b_i(start_b),
    .chip_id_i(chip_id), .ev_count_i(ev_count),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(mem_q),
    .dout_a_o(dout_a), .dout_b_o(dout_b),
    .txon_a_o(txon_a), .txon_b_o(txon_b),
    .end_a_o(end_a), .end_b_o(end_b)
  );

  function automatic logic [WORD_W-1:0] word_at(int a);
    return WORD_W'((a * 977 + seed * 131) ^ (a << 11) ^ (seed << 13));
  endfunction

  // storage with one-clock read latency (R10)
  always @(posedge clk) if (rd_en) mem_q <= word_at(int'(rd_addr));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic build_stream();
    int tot;
    tot = int'(ev_count) * (N_CH + 1);
    if (tot == 0) begin
      exp_q.push_back('{tx:1'b0, d:1'b0, e:1'b1});
      return;
    end
    exp_q.push_back('{tx:1'b1, d:1'b0, e:1'b0});
    for (int i = ID_W - 1; i >= 0; i--) exp_q.push_back('{tx:1'b1, d:chip_id[i], e:1'b0});
    for (int w = 0; w < tot; w++) begin
      logic [WORD_W-1:0] v;
      v = word_at(w);
      for (int b = WORD_W - 1; b >= 0; b--) exp_q.push_back('{tx:1'b1, d:v[b], e:1'b0});
    end
    exp_q.push_back('{tx:1'b1, d:1'b0, e:1'b0});
    exp_q.push_back('{tx:1'b0, d:1'b0, e:1'b1});
  endtask

  // reference model: accepts a token only when fully idle
  always @(posedge clk) begin
    if (!rst_n) begin
      model_busy = 1'b0;
      exp_q.delete();
    end else if (model_busy && exp_q.size() == 0) begin
      model_busy = 1'b0;
    end else if (!model_busy && (path_sel ? start_b : start_a)) begin
      model_busy = 1'b1;
      sel_m = path_sel;
      build_stream();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      slot_t x;
      x = (exp_q.size() != 0) ? exp_q.pop_front() : slot_t'(3'b000);
      chk("R3", "txon", int'(txon_a), int'(x.tx));
      chk(x.tx ? "R4" : "R5", "dout", int'(dout_a), int'(x.d));
      chk("R6", "end_sel", int'(sel_m ? end_b : end_a), int'(x.e));
      chk("R2", "end_other", int'(sel_m ? end_a : end_b), 0);
      chk("R9", "dup", int'({dout_b, txon_b}), int'({dout_a, txon_a}));
      end_seen += int'(end_a | end_b);
    end
  end

  task automatic pulse(logic a, logic b);
    @(negedge clk);
    start_a = a;
    start_b = b;
    @(negedge clk);
    start_a = 1'b0;
    start_b = 1'b0;
  endtask

  task automatic wait_done();
    do @(posedge clk); while (model_busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: outputs released in reset
    chk("R1", "outs_in_reset", int'({dout_a, dout_b, txon_a, txon_b, end_a, end_b}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R3 R10: two events on path a
    chip_id = 8'hA5; ev_count = 4'd2; seed = 3;
    pulse(1'b1, 1'b0);
    wait_done();

    // R2: unselected start input ignored
    base = end_seen;
    pulse(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R2", "ignored_start_b", end_seen - base, 0);

    // R2: path b with both inputs pulsed
    path_sel = 1'b1; chip_id = 8'h3C; ev_count = 4'd1; seed = 7;
    pulse(1'b1, 1'b1);
    wait_done();

    // R7: empty chip passes token immediately
    base = end_seen;
    ev_count = 4'd0;
    pulse(1'b0, 1'b1);
    wait_done();
    chk("R7", "empty_end_count", end_seen - base, 1);

    // R8: second token during readout ignored
    path_sel = 1'b0; chip_id = 8'h81; ev_count = 4'd3; seed = 11;
    base = end_seen;
    pulse(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    pulse(1'b1, 1'b0);
    wait_done();
    chk("R8", "busy_end_count", end_seen - base, 1);

    // R10: largest event count
    chip_id = 8'hFF; ev_count = 4'(EV_MAX); seed = 29;
    pulse(1'b1, 1'b0);
    wait_done();

    // R1: reset mid-readout releases the bus
    chip_id = 8'h12; ev_count = 4'd1; seed = 5;
    pulse(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "outs_after_reset", int'({dout_a, dout_b, txon_a, txon_b, end_a, end_b}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule